// File: doc/BRIEF.md
# Write-Once Power Mode Protection

This block decides which low power modes a processor is permitted to enter. It also screens every mode request against those permissions. Software programs a protection register over a small 8-bit register port. That register can be written only once after a full chip reset, so early boot code can grant or withhold each family of low power modes for the rest of the session.

Run-mode requests and stop-mode selections are written into a mode control register. A run-mode request that is not permitted, or that uses a reserved code, is dropped without any error, and the block stays in the mode it was in. A stop entry strobe is checked against the same permissions: a permitted stop gives a one-cycle grant pulse, and a refused stop sets an abort flag.

Two resets are provided. The full chip reset clears everything. The recovery reset, used when waking from the deepest stop mode, returns the mode state to normal run but keeps the protection register and its write-once lock.

Top module: `pmp_top`

## Requirements
- R1: While `chip_rst` is high and in the cycle after it falls, reads of address 0 and address 1 return 00h, `cur_mode` is 00b, and `stop_go` and `stop_abort` are 0.
- R2: The first write to address 0 after `chip_rst` stores the written byte ANDed with 2Ah. Bit 5 permits the very-low-power family (run, wait and stop), bit 3 permits low leakage stop, and bit 1 permits very low leakage stop. The stored value reads back at address 0 from the cycle after the write.
- R3: The first write to address 0 sets a lock, even if the written byte is 00h. While the lock is set, every later write to address 0 leaves the stored value unchanged. Only `chip_rst` clears the lock.
- R4: Bits 7, 6, 4, 2 and 0 of address 0 always read as 0, whatever was written to them.
- R5: A write to address 1 carries the run request in bits 6:5. Code 00b (normal run) is always accepted. Code 10b (very low power run) is accepted only when protection bit 5 is 1. The accepted run mode reads back in bits 6:5 of address 1.
- R6: A run request that is not permitted, or that uses a reserved code (01b or 11b), leaves the run mode unchanged.
- R7: `deep_rst` returns the run mode to 00b and clears the stop select, `stop_go` and `stop_abort`. It leaves the protection value and the lock unchanged. Bus writes made while `deep_rst` is high are ignored.
- R8: `cur_mode` equals the run mode that was in effect one clock earlier, so it follows an accepted request one cycle after the register readback.
- R9: Bits 2:0 of a write to address 1 set the stop select: 000b normal stop (always permitted), 010b very-low-power stop (needs bit 5), 011b low leakage stop (needs bit 3), 100b very low leakage stop (needs bit 1). When `stop_req` is sampled high with a permitted select, `stop_go` is high for exactly the next cycle and `stop_abort` clears.
- R10: When `stop_req` is sampled high with a select that is not permitted or is reserved (001b, 101b, 110b, 111b), `stop_go` stays 0 and `stop_abort` becomes 1. `stop_abort` reads back in bit 7 of address 1 and holds until the next stop strobe or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| chip_rst | input | 1 | Full chip reset, synchronous, active high |
| deep_rst | input | 1 | Recovery reset that keeps the protection state, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 is protection, 1 is mode control, other addresses read 0 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| stop_req | input | 1 | Stop entry strobe |
| cur_mode | output | 2 | Run mode in effect (00b normal, 10b very low power) |
| stop_go | output | 1 | One-cycle pulse granting a stop entry |
| stop_abort | output | 1 | The last stop attempt was refused |

## Verification
The bench sweeps all eight combinations of the three permission bits. Every write also sets the reserved bits, so a mask that keeps the wrong bits shows up at once. For each combination it tries all four run-request codes, both from normal run and from very low power run. This separates a wrong permission bit from a reserved code that is wrongly accepted, and from a missing hold of the previous mode.

Against the same combinations it tries all eight stop selects, which separates the per-mode permission decode from the reserved-code rejection and the abort bookkeeping. Separate sequences cover the following:
- a first write of all zeros, which must still set the lock;
- a second write, which must be refused;
- a recovery reset, which must keep the permissions and the lock while returning the mode to normal run.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int SEL_W  = 3;

    localparam logic [ADDR_W-1:0] ADDR_PROT = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;

    // permission bit positions inside the protection register
    localparam int BIT_VLP = 5;
    localparam int BIT_LL  = 3;
    localparam int BIT_VLL = 1;
    localparam logic [DATA_W-1:0] PROT_MASK =
        (DATA_W'(1) << BIT_VLP) | (DATA_W'(1) << BIT_LL) | (DATA_W'(1) << BIT_VLL);

    // control register field positions
    localparam int RUN_LSB   = 5;
    localparam int ABORT_BIT = 7;

    typedef enum logic [1:0] {
        RUN_NORMAL = 2'b00,
        RUN_RSV1   = 2'b01,
        RUN_VLP    = 2'b10,
        RUN_RSV3   = 2'b11
    } run_e;

    localparam logic [SEL_W-1:0] STOP_NORMAL = 3'd0;
    localparam logic [SEL_W-1:0] STOP_VLP    = 3'd2;
    localparam logic [SEL_W-1:0] STOP_LL     = 3'd3;
    localparam logic [SEL_W-1:0] STOP_VLL    = 3'd4;

    typedef struct packed {
        logic vlp;
        logic ll;
        logic vll;
    } perm_t;

    function automatic perm_t perm_of(logic [DATA_W-1:0] prot);
        perm_t g;
        g.vlp = prot[BIT_VLP];
        g.ll  = prot[BIT_LL];
        g.vll = prot[BIT_VLL];
        return g;
    endfunction

    function automatic logic run_ok(run_e req, perm_t g);
        case (req)
            RUN_NORMAL: return 1'b1;
            RUN_VLP:    return g.vlp;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic stop_ok(logic [SEL_W-1:0] sel, perm_t g);
        case (sel)
            STOP_NORMAL: return 1'b1;
            STOP_VLP:    return g.vlp;
            STOP_LL:     return g.ll;
            STOP_VLL:    return g.vll;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pmp_prot_reg.sv
module pmp_prot_reg
    import pmp_pkg::*;
(
    input  logic              clk,
    input  logic              chip_rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] prot,
    output logic              locked
);

    // only the full chip reset touches this state
    always_ff @(posedge clk) begin
        if (chip_rst) begin
            prot   <= '0;
            locked <= 1'b0;
        end else if (wr && !locked) begin
            prot   <= wdata & PROT_MASK;
            locked <= 1'b1;
        end
    end

endmodule

// File: rtl/pmp_mode_ctrl.sv
module pmp_mode_ctrl
    import pmp_pkg::*;
(
    input  logic             clk,
    input  logic             chip_rst,
    input  logic             deep_rst,
    input  perm_t            perm,
    input  logic             wr,
    input  logic [1:0]       run_req,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             stop_req,
    output run_e             run_mode,
    output logic [SEL_W-1:0] stop_sel,
    output run_e             cur_mode,
    output logic             stop_go,
    output logic             stop_abort
);

    logic rst;
    logic req_ok;
    logic sel_ok;

    assign rst    = chip_rst | deep_rst;
    assign req_ok = run_ok(run_e'(run_req), perm);
    assign sel_ok = stop_ok(stop_sel, perm);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_mode <= RUN_NORMAL;
            stop_sel <= STOP_NORMAL;
        end else if (wr) begin
            if (req_ok)
                run_mode <= run_e'(run_req);
            stop_sel <= sel_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_mode <= RUN_NORMAL;
        else
            cur_mode <= run_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_go    <= 1'b0;
            stop_abort <= 1'b0;
        end else if (stop_req) begin
            stop_go    <= sel_ok;
            stop_abort <= !sel_ok;
        end else begin
            stop_go    <= 1'b0;
        end
    end

endmodule

// File: rtl/pmp_top.sv
module pmp_top
    import pmp_pkg::*;
(
    input  logic              clk,
    input  logic              chip_rst,
    input  logic              deep_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              stop_req,
    output logic [1:0]        cur_mode,
    output logic              stop_go,
    output logic              stop_abort
);

    logic              wr_ok;
    logic              wr_prot;
    logic              wr_ctrl;
    logic [DATA_W-1:0] prot;
    logic              locked;
    perm_t             perm;
    run_e              run_mode;
    run_e              cur_mode_e;
    logic [SEL_W-1:0]  stop_sel;
    logic [DATA_W-1:0] ctrl_rd;

    assign wr_ok   = wr_en && !deep_rst;
    assign wr_prot = wr_ok && (addr == ADDR_PROT);
    assign wr_ctrl = wr_ok && (addr == ADDR_CTRL);
    assign perm    = perm_of(prot);

    pmp_prot_reg u_prot (
        .clk      (clk),
        .chip_rst (chip_rst),
        .wr       (wr_prot),
        .wdata    (wdata),
        .prot     (prot),
        .locked   (locked)
    );

    pmp_mode_ctrl u_mode (
        .clk        (clk),
        .chip_rst   (chip_rst),
        .deep_rst   (deep_rst),
        .perm       (perm),
        .wr         (wr_ctrl),
        .run_req    (wdata[RUN_LSB +: 2]),
        .sel_in     (wdata[SEL_W-1:0]),
        .stop_req   (stop_req),
        .run_mode   (run_mode),
        .stop_sel   (stop_sel),
        .cur_mode   (cur_mode_e),
        .stop_go    (stop_go),
        .stop_abort (stop_abort)
    );

    always_comb begin
        ctrl_rd                  = '0;
        ctrl_rd[ABORT_BIT]       = stop_abort;
        ctrl_rd[RUN_LSB +: 2]    = run_mode;
        ctrl_rd[SEL_W-1:0]       = stop_sel;
    end

    always_comb begin
        case (addr)
            ADDR_PROT: rdata = prot;
            ADDR_CTRL: rdata = ctrl_rd;
            default:   rdata = '0;
        endcase
    end

    assign cur_mode = cur_mode_e;

endmodule

// File: rtl/pmp_check.sv
module pmp_check
    import pmp_pkg::*;
(
    input logic              clk,
    input logic              chip_rst,
    input logic              deep_rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              stop_req,
    input logic [1:0]        cur_mode,
    input logic              stop_go,
    input logic              stop_abort,
    input logic [DATA_W-1:0] prot,
    input logic              locked,
    input logic [1:0]        run_mode,
    input logic [SEL_W-1:0]  stop_sel
);

    perm_t g;
    assign g = perm_of(prot);

    // R3: a locked protection register does not change on a write
    p_write_once_r3: assert property (@(posedge clk) disable iff (chip_rst)
        (wr_en && addr == ADDR_PROT && locked) |=> (prot == $past(prot)));

    // R3: the lock never drops without a chip reset
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (chip_rst)
        locked |=> locked);

    // R4: reserved bits read zero
    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (chip_rst)
        (addr == ADDR_PROT) |-> ((rdata & ~PROT_MASK) == '0));

    // R6: run mode never holds a reserved or unpermitted code
    p_run_legal_r6: assert property (@(posedge clk) disable iff (chip_rst)
        (run_mode == 2'b00) || (run_mode == 2'b10 && g.vlp));

    // R7: recovery reset keeps protection and lock
    p_deep_keep_r7: assert property (@(posedge clk) disable iff (chip_rst)
        deep_rst |=> (prot == $past(prot) && locked == $past(locked)));

    // R7: recovery reset returns to normal run
    p_deep_run_r7: assert property (@(posedge clk) disable iff (chip_rst)
        deep_rst |=> (run_mode == 2'b00 && !stop_go && !stop_abort));

    // R8: status lags the run mode by one clock
    p_status_lag_r8: assert property (@(posedge clk) disable iff (chip_rst)
        !deep_rst |=> (cur_mode == $past(run_mode)));

    // R9: permitted stop is granted for one cycle
    p_stop_go_r9: assert property (@(posedge clk) disable iff (chip_rst)
        (stop_req && !deep_rst && stop_ok(stop_sel, g)) |=> (stop_go && !stop_abort));

    // R9: grant is never longer than one cycle without a new strobe
    p_stop_pulse_r9: assert property (@(posedge clk) disable iff (chip_rst)
        (!stop_req) |=> !stop_go);

    // R10: refused stop sets the abort flag
    p_stop_abort_r10: assert property (@(posedge clk) disable iff (chip_rst)
        (stop_req && !deep_rst && !stop_ok(stop_sel, g)) |=> (stop_abort && !stop_go));

endmodule

bind pmp_top pmp_check u_chk (
    .clk        (clk),
    .chip_rst   (chip_rst),
    .deep_rst   (deep_rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .rdata      (rdata),
    .stop_req   (stop_req),
    .cur_mode   (cur_mode),
    .stop_go    (stop_go),
    .stop_abort (stop_abort),
    .prot       (prot),
    .locked     (locked),
    .run_mode   (run_mode),
    .stop_sel   (stop_sel)
);

// File: tb/sim_pmp_top.sv
`timescale 1ns/1ps
module sim_pmp_top;

    logic       clk = 1'b0;
    logic       chip_rst = 1'b1;
    logic       deep_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       stop_req = 1'b0;
    logic [1:0] cur_mode;
    logic       stop_go;
    logic       stop_abort;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pmp_top u0 (
        .clk(clk), .chip_rst(chip_rst), .deep_rst(deep_rst),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .stop_req(stop_req), .cur_mode(cur_mode),
        .stop_go(stop_go), .stop_abort(stop_abort)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_chip_rst();
        chip_rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chip_rst = 1'b0;
    endtask

    function automatic int stop_allowed(int s, int p);
        case (s)
            0: return 1;
            2: return (p >> 5) & 1;
            3: return (p >> 3) & 1;
            4: return (p >> 1) & 1;
            default: return 0;
        endcase
    endfunction

    initial begin
        logic [7:0] v;
        @(negedge clk); @(negedge clk);
        // reset state
        rd(2'd0, v); chk("R1 prot in reset", v, 0);
        rd(2'd1, v); chk("R1 ctrl in reset", v, 0);
        chk("R1 cur_mode in reset", cur_mode, 0);
        chip_rst = 1'b0;
        @(negedge clk);
        rd(2'd0, v); chk("R1 prot after reset", v, 0);
        rd(2'd1, v); chk("R1 ctrl after reset", v, 0);
        chk("R1 stop_go after reset", stop_go, 0);
        chk("R1 stop_abort after reset", stop_abort, 0);

        // a first write of zeros still locks
        wr(2'd0, 8'h00);
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R3 zero write locks", v, 0);

        for (int c = 0; c < 8; c++) begin
            int p, avlp;
            p = ((c >> 2) & 1) * 32 + ((c >> 1) & 1) * 8 + (c & 1) * 2;
            avlp = (p >> 5) & 1;
            do_chip_rst();
            wr(2'd0, 8'(p) | 8'hD5);
            rd(2'd0, v);
            chk("R2 protection readback", v, p);
            chk("R4 reserved bits zero", v & 8'hD5, 0);
            wr(2'd0, ~8'(p));
            rd(2'd0, v); chk("R3 second write ignored", v, p);

            for (int start = 0; start < 2; start++) begin
                int base;
                base = (start == 1 && avlp == 1) ? 2 : 0;
                for (int r = 0; r < 4; r++) begin
                    int exp;
                    wr(2'd1, 8'(base << 5));
                    exp = (r == 0) ? 0 : ((r == 2 && avlp == 1) ? 2 : base);
                    wr(2'd1, 8'(r << 5));
                    rd(2'd1, v);
                    if (r == 0 || r == 2)
                        chk("R5 run request", (v >> 5) & 3, exp);
                    else
                        chk("R6 reserved run code kept", (v >> 5) & 3, exp);
                    @(negedge clk);
                    chk("R8 status follows run mode", cur_mode, exp);
                end
            end

            for (int s = 0; s < 8; s++) begin
                int ok;
                ok = stop_allowed(s, p);
                wr(2'd1, 8'(s));
                stop_req = 1'b1;
                @(negedge clk);
                stop_req = 1'b0;
                if (ok == 1) begin
                    chk("R9 stop granted", stop_go, 1);
                    chk("R9 abort cleared", stop_abort, 0);
                end else begin
                    chk("R10 stop refused", stop_go, 0);
                    chk("R10 abort set", stop_abort, 1);
                end
                rd(2'd1, v);
                chk("R10 abort readback", (v >> 7) & 1, 1 - ok);
                @(negedge clk);
                chk("R9 grant one cycle", stop_go, 0);
                chk("R10 abort held", stop_abort, 1 - ok);
            end
        end

        // recovery reset keeps protection and lock
        do_chip_rst();
        wr(2'd0, 8'h2A);
        wr(2'd1, 8'h41);
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        deep_rst = 1'b1;
        wr(2'd0, 8'h00);
        deep_rst = 1'b0;
        rd(2'd0, v); chk("R7 protection kept", v, 8'h2A);
        rd(2'd1, v); chk("R7 control cleared", v, 0);
        chk("R7 abort cleared", stop_abort, 0);
        @(negedge clk);
        chk("R7 status normal run", cur_mode, 0);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R7 lock kept", v, 8'h2A);

        // writes during recovery reset are ignored, lock stays clear
        do_chip_rst();
        deep_rst = 1'b1;
        wr(2'd0, 8'h2A);
        deep_rst = 1'b0;
        rd(2'd0, v); chk("R7 write during reset ignored", v, 0);
        wr(2'd0, 8'h08);
        rd(2'd0, v); chk("R7 lock not set by ignored write", v, 8'h08);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule